// File: doc/BRIEF.md
# Periodic Countdown Timer with Two-Strike Watchdog

This block is a register-mapped countdown timer advanced by an external 1 MHz tick enable. Software programs a control word that holds a run flag, a repeat flag and a start value. The live count falls by one on each tick. When a tick arrives while the count is already zero, that tick is an *expiry*. An expiry sets a pending interrupt. In repeat mode the count then reloads. In single-shot mode the timer stops itself.

The same expiries drive a watchdog. One unanswered expiry is tolerated. A reset request pulse goes out only when an expiry arrives while the previous one is still unanswered, so the effective timeout is two periods. A read of the control word answers an expiry. Clearing the interrupt is also needed to drop the interrupt line, but a clear alone does not answer the watchdog. Turning the timer off forgets any unanswered expiry.

The watchdog is a four-state machine:
- `DOG_IDLE`: the timer is stopped.
- `DOG_ARMED`: the timer is running and nothing is owed. An expiry moves it to `DOG_OWED`.
- `DOG_OWED`: one expiry is unanswered. A control read returns it to `DOG_ARMED`. An expiry with no control read in the same cycle moves it to `DOG_BITE`. An expiry together with a control read keeps it in `DOG_OWED`.
- `DOG_BITE`: lasts one cycle and raises the reset request. It then moves to `DOG_OWED`. If that cycle also brings a control read with no expiry, it moves to `DOG_ARMED` instead.

From any state, the machine goes to `DOG_IDLE` whenever the timer is not running or a control write clears the run flag. `DOG_IDLE` leaves for `DOG_ARMED` once the timer runs, or for `DOG_OWED` if an expiry already occurs.

Top module: `dog_timer`

## Requirements
- R1: After reset, both registers read as zero, `irq` is low and `dog_rst` is low.
- R2: The control word sits at address 0, with the run flag at bit 31, the repeat flag at bit 30 and the start value in bits 28:0. Bit 29 reads as zero. A write stores all three fields and loads the count with the start value.
- R3: While running, the count decreases by one on each cycle with `tick_en` high. It holds when there is no tick or the timer is stopped.
- R4: A start value N gives an expiry every N+1 ticks. The expiry is the tick that finds the count at zero. In repeat mode the count is N again after that tick.
- R5: In single-shot mode (bit 30 = 0), an expiry clears the run flag and the count stays at zero on later ticks.
- R6: An expiry sets `irq`. `irq` stays high until a write to address 1 with bit 30 = 1. If an expiry and a clear happen in the same cycle, the expiry wins. A write to the control word in the same cycle as a zero-count tick suppresses that expiry.
- R7: A read of address 1 returns the pending interrupt at bit 30, the live count in bits 28:0 and zeros elsewhere. Writes to its count bits have no effect.
- R8: `dog_rst` is high for exactly one cycle: the cycle after an expiry that arrives while the previous expiry is unanswered. A second pulse never follows directly.
- R9: A read of the control word answers an outstanding expiry. An interrupt clear alone does not.
- R10: Writing zero to both registers stops the timer. While stopped, `dog_rst` stays low and any unanswered expiry is forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 1 MHz count enable, one cycle wide |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control word, 1 = status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe, zero otherwise |
| irq | output | 1 | Pending expiry interrupt |
| dog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume a single-bit address, with at most one access per cycle. They also assume `tick_en` may be high in any cycle, including back-to-back. The pulse property therefore has to hold even with a start value of zero, which gives an expiry on every tick.

The stimulus keeps start values small (0 to 5) so that expiries, bites and answered expiries happen often. It also drives `tick_en` and accesses at random, so expiries land in the same cycle as clears, control reads and control writes.

// File: rtl/dog_timer_pkg.sv
package dog_timer_pkg;
    localparam int DT_DATA_W = 32;
    localparam int DT_CNT_W  = 29;

    typedef enum logic [1:0] {
        DOG_IDLE  = 2'd0,
        DOG_ARMED = 2'd1,
        DOG_OWED  = 2'd2,
        DOG_BITE  = 2'd3
    } dog_state_e;
endpackage

// File: rtl/dog_timer_decode.sv
module dog_timer_decode #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              run,
    input  logic              periodic,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  count,
    input  logic              irq,
    output logic              ctl_wr,
    output logic              ctl_rd,
    output logic              wr_run,
    output logic              wr_mode,
    output logic [CNT_W-1:0]  wr_value,
    output logic              irq_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int RUN_BIT  = DATA_W - 1;
    localparam int MODE_BIT = DATA_W - 2;
    localparam int ACK_BIT  = DATA_W - 2;

    logic do_wr;
    logic do_rd;
    logic unused_wdata;

    assign do_wr   = bus_sel && bus_wr;
    assign do_rd   = bus_sel && !bus_wr;
    assign ctl_wr  = do_wr && !bus_addr;
    assign ctl_rd  = do_rd && !bus_addr;
    assign irq_clr = do_wr && bus_addr && bus_wdata[ACK_BIT];

    assign wr_run   = bus_wdata[RUN_BIT];
    assign wr_mode  = bus_wdata[MODE_BIT];
    assign wr_value = bus_wdata[CNT_W-1:0];

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            if (!bus_addr) begin
                bus_rdata[RUN_BIT]     = run;
                bus_rdata[MODE_BIT]    = periodic;
                bus_rdata[CNT_W-1:0]   = reload;
            end else begin
                bus_rdata[ACK_BIT]     = irq;
                bus_rdata[CNT_W-1:0]   = count;
            end
        end
    end
endmodule

// File: rtl/dog_timer_counter.sv
module dog_timer_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic             load_run,
    input  logic             load_mode,
    input  logic [CNT_W-1:0] load_value,
    input  logic             irq_clr,
    output logic             run,
    output logic             periodic,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             run_q;
    logic             mode_q;
    logic [CNT_W-1:0] rel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    assign expire = tick_en && run_q && (cnt_q == CNT_ZERO) && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= 1'b0;
            rel_q  <= CNT_ZERO;
            cnt_q  <= CNT_ZERO;
        end else if (load) begin
            run_q  <= load_run;
            mode_q <= load_mode;
            rel_q  <= load_value;
            cnt_q  <= load_value;
        end else if (tick_en && run_q) begin
            if (cnt_q == CNT_ZERO) begin
                if (mode_q) begin
                    cnt_q <= rel_q;
                end else begin
                    run_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign run      = run_q;
    assign periodic = mode_q;
    assign reload   = rel_q;
    assign count    = cnt_q;
    assign irq      = irq_q;
endmodule

// File: rtl/dog_timer_fsm.sv
module dog_timer_fsm
    import dog_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic disarm,
    input  logic expire,
    input  logic service,
    output logic bite
);
    dog_state_e state_q;
    dog_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!run || disarm) begin
            state_d = DOG_IDLE;
        end else begin
            unique case (state_q)
                DOG_IDLE:  state_d = expire ? DOG_OWED : DOG_ARMED;
                DOG_ARMED: state_d = expire ? DOG_OWED : DOG_ARMED;
                DOG_OWED: begin
                    if (expire)       state_d = service ? DOG_OWED : DOG_BITE;
                    else if (service) state_d = DOG_ARMED;
                    else              state_d = DOG_OWED;
                end
                DOG_BITE: begin
                    if (!expire && service) state_d = DOG_ARMED;
                    else                    state_d = DOG_OWED;
                end
                default:   state_d = DOG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DOG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bite = (state_q == DOG_BITE);
    end
endmodule

// File: rtl/dog_timer.sv
module dog_timer
    import dog_timer_pkg::*;
#(
    parameter int DATA_W = DT_DATA_W,
    parameter int CNT_W  = DT_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dog_rst
);
    logic             ctl_wr;
    logic             ctl_rd;
    logic             wr_run;
    logic             wr_mode;
    logic [CNT_W-1:0] wr_value;
    logic             irq_clr;
    logic             run;
    logic             periodic;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cur_count;
    logic             expire;
    logic             irq_int;
    logic             disarm;

    assign disarm = ctl_wr && !wr_run;

    dog_timer_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .run       (run),
        .periodic  (periodic),
        .reload    (reload),
        .count     (cur_count),
        .irq       (irq_int),
        .ctl_wr    (ctl_wr),
        .ctl_rd    (ctl_rd),
        .wr_run    (wr_run),
        .wr_mode   (wr_mode),
        .wr_value  (wr_value),
        .irq_clr   (irq_clr),
        .bus_rdata (bus_rdata)
    );

    dog_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .load       (ctl_wr),
        .load_run   (wr_run),
        .load_mode  (wr_mode),
        .load_value (wr_value),
        .irq_clr    (irq_clr),
        .run        (run),
        .periodic   (periodic),
        .reload     (reload),
        .count      (cur_count),
        .expire     (expire),
        .irq        (irq_int)
    );

    dog_timer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .disarm  (disarm),
        .expire  (expire),
        .service (ctl_rd),
        .bite    (dog_rst)
    );

    assign irq = irq_int;
endmodule

// File: rtl/dog_timer_checker.sv
module dog_timer_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              dog_rst,
    input logic [CNT_W-1:0]  cur_count,
    input logic              run,
    input logic              periodic,
    input logic              expire
);
    logic clr_req;
    logic ctl_write;

    assign clr_req   = bus_sel && bus_wr && bus_addr && bus_wdata[DATA_W-2];
    assign ctl_write = bus_sel && bus_wr && !bus_addr;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dog_rst |=> !dog_rst);

    a_r8_bite_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dog_rst |-> irq);

    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_req) |=> irq);

    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ctl_write) |=> $stable(cur_count));

    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> !run);

    a_r10_stop_no_bite: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_write && !bus_wdata[DATA_W-1]) |=> (!dog_rst && !run));
endmodule

bind dog_timer dog_timer_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .dog_rst   (dog_rst),
    .cur_count (cur_count),
    .run       (run),
    .periodic  (periodic),
    .expire    (expire)
);

// File: tb/dog_timer_bench.sv
module dog_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        dog_rst;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] last_rd;

    logic        m_run, m_per, m_irq;
    logic [28:0] m_rel, m_cnt;
    int          m_dog;

    always #(CLK_PERIOD/2) clk = ~clk;

    dog_timer u_dog_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dog_rst(dog_rst)
    );

    function automatic logic [31:0] exp_ctl();
        return {m_run, m_per, 1'b0, m_rel};
    endfunction

    function automatic logic [31:0] exp_stat();
        return {1'b0, m_irq, 1'b0, m_cnt};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_next(input logic sel, input logic wr, input logic adr,
                              input logic [31:0] wd, input logic tk);
        logic tw, tr, clr, ex, off;
        int nd;
        tw  = sel && wr && !adr;
        tr  = sel && !wr && !adr;
        clr = sel && wr && adr && wd[30];
        ex  = tk && m_run && (m_cnt == 0) && !tw;
        off = !m_run || (tw && !wd[31]);
        nd = m_dog;
        if (off) nd = 0;
        else if (m_dog == 0 || m_dog == 1) nd = ex ? 2 : 1;
        else if (m_dog == 2) begin
            if (ex && !tr) nd = 3;
            else if (!ex && tr) nd = 1;
            else nd = 2;
        end else nd = (!ex && tr) ? 1 : 2;
        m_dog = nd;
        if (ex) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
        if (tw) begin
            m_run = wd[31]; m_per = wd[30]; m_rel = wd[28:0]; m_cnt = wd[28:0];
        end else if (tk && m_run) begin
            if (m_cnt == 0) begin
                if (m_per) m_cnt = m_rel;
                else m_run = 1'b0;
            end else m_cnt = m_cnt - 1;
        end
    endtask

    task automatic step(input logic sel, input logic wr, input logic adr,
                        input logic [31:0] wd, input logic tk);
        bus_sel = sel; bus_wr = wr; bus_addr = adr; bus_wdata = wd; tick_en = tk;
        #1;
        last_rd = bus_rdata;
        if (sel && !wr) chk(adr ? "R7 status read" : "R2 control read",
                            bus_rdata, adr ? exp_stat() : exp_ctl());
        else chk("R7 idle rdata", bus_rdata, 32'h0);
        model_next(sel, wr, adr, wd, tk);
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq", {31'b0, irq}, {31'b0, m_irq});
        chk("R8 dog_rst", {31'b0, dog_rst}, {31'b0, (m_dog == 3)});
        bus_sel = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_run = 0; m_per = 0; m_irq = 0; m_rel = '0; m_cnt = '0; m_dog = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 dog_rst after reset", {31'b0, dog_rst}, 32'h0);
        step(1, 0, 0, 32'h0, 0); chk("R1 control zero", last_rd, 32'h0);
        step(1, 0, 1, 32'h0, 0); chk("R1 status zero", last_rd, 32'h0);

        // R2 / R3 / R4: repeat mode, start value 3
        step(1, 1, 0, 32'hE000_0003, 0);
        step(1, 0, 0, 32'h0, 0); chk("R2 bit29 reads zero", last_rd, 32'hC000_0003);
        step(1, 0, 1, 32'h0, 0); chk("R2 count loaded", last_rd, 32'h0000_0003);
        ticks(2);
        step(1, 0, 1, 32'h0, 0); chk("R3 two ticks", last_rd, 32'h0000_0001);
        step(0, 0, 0, 32'h0, 0); step(0, 0, 0, 32'h0, 0);
        step(1, 0, 1, 32'h0, 0); chk("R3 hold without tick", last_rd, 32'h0000_0001);
        ticks(1);
        chk("R4 no expiry at zero", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R4 expiry on N+1 tick", {31'b0, irq}, 32'h1);
        step(1, 0, 1, 32'h0, 0); chk("R4 reload after expiry", last_rd, 32'h4000_0003);

        // R7: count bits not writable; R9: clear alone does not answer
        step(1, 1, 1, 32'h4000_0155, 0);
        chk("R6 clear drops irq", {31'b0, irq}, 32'h0);
        step(1, 0, 1, 32'h0, 0); chk("R7 count unwritable", last_rd, 32'h0000_0003);
        ticks(4);
        chk("R9 clear alone bites", {31'b0, dog_rst}, 32'h1);
        step(0, 0, 0, 32'h0, 0);
        chk("R8 pulse one cycle", {31'b0, dog_rst}, 32'h0);

        // R9: control read answers
        step(1, 0, 0, 32'h0, 0);
        ticks(4);
        chk("R9 answered no bite", {31'b0, dog_rst}, 32'h0);
        step(1, 0, 0, 32'h0, 0);
        ticks(4);
        chk("R9 answered again no bite", {31'b0, dog_rst}, 32'h0);

        // R5: single shot
        step(1, 1, 0, 32'h8000_0001, 0);
        step(1, 0, 0, 32'h0, 0);
        ticks(2);
        step(1, 0, 0, 32'h0, 0); chk("R5 run cleared", last_rd, 32'h0000_0001);
        ticks(3);
        step(1, 0, 1, 32'h0, 0); chk("R5 count stays zero", last_rd, 32'h4000_0000);

        // R10: start value zero bites, then stop by zero writes
        step(1, 1, 0, 32'hC000_0000, 0);
        ticks(4);
        step(1, 1, 0, 32'h0, 1);
        step(1, 1, 1, 32'h0, 1);
        for (int i = 0; i < 10; i++) begin
            step(0, 0, 0, 32'h0, 1);
            chk("R10 no bite while stopped", {31'b0, dog_rst}, 32'h0);
        end
        step(1, 0, 0, 32'h0, 0); chk("R10 control zero", last_rd, 32'h0);
        step(1, 1, 1, 32'h4000_0000, 0);

        // Random phase against the model (R2..R10)
        step(1, 1, 0, 32'hC000_0002, 0);
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] wd;
            logic tk;
            op = $urandom_range(99);
            tk = ($urandom_range(1) == 1);
            wd = $urandom;
            if (op < 55)       step(0, 0, 0, 32'h0, tk);
            else if (op < 68)  step(1, 0, 0, 32'h0, tk);
            else if (op < 76)  step(1, 0, 1, 32'h0, tk);
            else if (op < 88)  step(1, 1, 1, wd, tk);
            else begin
                wd[29:0] = {1'b0, wd[29], 26'b0, 3'($urandom_range(5))};
                wd[31] = ($urandom_range(7) != 0);
                step(1, 1, 0, wd, tk);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule